// File: doc/BRIEF.md
# Neighbour-Sum Hit Trigger

This block watches a group of strip channels whose amplitudes arrive already digitised, one whole sample at a time on a parallel bus. For every channel it adds that channel's amplitude to the amplitudes of a small window of neighbours. It then compares the sum with a threshold that is programmed separately for each channel. A channel is marked hit when its sum reaches the threshold. The mark is removed only when the sum drops below a lower release level, so a sum that wanders near the threshold does not make the flag toggle.

The per-channel flags form a hit mask. When the mask changes from empty to non-empty, the block raises a single-cycle trigger pulse. This pulse serves as the on-chip trigger source, as an alternative to an external trigger. One instance covers one group of 32 channels, and a wider front end places several instances side by side.

Top module: `zs_neighbour_trigger`

## Requirements
- R1: While reset is active and after it is released, `hit_mask` is all zero and `trig_pulse` is low. Every threshold resets to all ones and the hysteresis resets to zero, so no channel can be hit until a threshold is written.
- R2: With `win_sel` = 0, the sum for channel i is amp[i-1] + amp[i] + amp[i+1]. A neighbour index outside 0..NCH-1 adds zero. Channel i occupies bits i*AW +: AW of `amp_bus`.
- R3: With `win_sel` = 1, the sum covers channels i-1 to i+2 (four channels). With `win_sel` = 2 or 3, it covers channels i-2 to i+2 (five channels). Missing edge neighbours add zero.
- R4: A cycle with `thr_we` high stores `thr_data` as the threshold of channel `thr_addr`. If `thr_addr` >= NCH, the write changes no threshold. A cycle with `hyst_we` high stores `hyst_data` as the global hysteresis. A new value is used from the next clock edge on.
- R5: At a clock edge where `sample_valid` is high, a channel whose sum is greater than or equal to its threshold has its flag set. The new mask is visible after that edge.
- R6: The release level is the threshold minus the hysteresis, or zero if the hysteresis exceeds the threshold. On a valid sample, a set flag clears when the sum is below the release level. When the sum lies from the release level up to one below the threshold, the flag keeps its value.
- R7: At an edge where `sample_valid` is low, `hit_mask` does not change, whatever the amplitudes are.
- R8: `trig_pulse` is high for exactly one cycle, in the first cycle in which `hit_mask` is non-zero after a cycle in which it was zero.
- R9: Sums are AW+3 bits wide and are never truncated. The largest five-channel sum, 5*(2^AW-1), can hit a threshold programmed to that same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Marks a cycle carrying a new sample |
| win_sel | input | 2 | Neighbour window: 0 = three, 1 = four, 2/3 = five channels |
| amp_bus | input | NCH*AW | Digitised amplitudes of all channels |
| thr_we | input | 1 | Threshold write strobe |
| thr_addr | input | clog2(NCH)+1 | Channel selected by a threshold write |
| thr_data | input | AW+3 | Threshold value |
| hyst_we | input | 1 | Hysteresis write strobe |
| hyst_data | input | AW+3 | Hysteresis band |
| hit_mask | output | NCH | Per-channel hit flags |
| trig_pulse | output | 1 | One-cycle internal trigger |

## Verification
The first pattern is a single isolated pulse in the middle of the group. It shows whether the three-channel sum reaches exactly the neighbours on both sides, and whether the per-channel thresholds separate channels whose sums are equal.

The second pattern lowers the pulse step by step. This separates the hold region from the release region of the hysteresis, including the case where the hysteresis exceeds the threshold.

The third pattern places pulses at both ends of the bus under all three window sizes. This exposes wrong reach or wrong edge padding. A full-scale five-channel pattern then probes the sum width.

The last pattern is a long pseudo-random stream with gaps in `sample_valid`, changing windows and an out-of-range threshold write. It compares the mask and the trigger edge on every cycle against the behavioural model.

// File: rtl/zs_pkg.sv
package zs_pkg;
  typedef enum logic [1:0] {
    WIN_THREE = 2'd0,
    WIN_FOUR  = 2'd1,
    WIN_FIVE  = 2'd2,
    WIN_FIVEX = 2'd3
  } win_e;

  // reach below the centre channel
  function automatic int reach_dn(win_e w);
    return (w == WIN_FIVE || w == WIN_FIVEX) ? 2 : 1;
  endfunction

  // reach above the centre channel
  function automatic int reach_up(win_e w);
    return (w == WIN_THREE) ? 1 : 2;
  endfunction

  function automatic logic tap_used(win_e w, int off);
    return (off >= -reach_dn(w)) && (off <= reach_up(w));
  endfunction
endpackage

// File: rtl/zs_win_sum.sv
module zs_win_sum
  import zs_pkg::*;
#(
  parameter int NCH = 32,
  parameter int AW  = 8,
  parameter int SW  = AW + 3
) (
  input  logic [NCH*AW-1:0] amp_bus,
  input  win_e              win,
  output logic [NCH*SW-1:0] sum_flat
);
  localparam int PAD = 2;
  localparam int PW  = (NCH + 2*PAD) * AW;

  // zero padding stands in for the absent edge neighbours
  logic [PW-1:0] padded;
  assign padded = {{(PAD*AW){1'b0}}, amp_bus, {(PAD*AW){1'b0}}};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [SW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int off = -PAD; off <= PAD; off++) begin
        if (tap_used(win, off))
          acc = acc + SW'(padded[(ch + off + PAD)*AW +: AW]);
      end
    end
    assign sum_flat[ch*SW +: SW] = acc;
  end
endmodule

// File: rtl/zs_thr_bank.sv
module zs_thr_bank #(
  parameter int NCH = 32,
  parameter int SW  = 11,
  parameter int AAW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              thr_we,
  input  logic [AAW-1:0]    thr_addr,
  input  logic [SW-1:0]     thr_data,
  input  logic              hyst_we,
  input  logic [SW-1:0]     hyst_data,
  output logic [NCH*SW-1:0] thr_flat,
  output logic [NCH*SW-1:0] rel_flat
);
  function automatic logic [SW-1:0] release_of(logic [SW-1:0] t, logic [SW-1:0] h);
    return (t > h) ? (t - h) : '0;
  endfunction

  logic [SW-1:0] hyst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hyst_q <= '0;
    else if (hyst_we) hyst_q <= hyst_data;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_thr
    logic [SW-1:0] thr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) thr_q <= '1;
      else if (thr_we && thr_addr == AAW'(i)) thr_q <= thr_data;
    end
    assign thr_flat[i*SW +: SW] = thr_q;
    assign rel_flat[i*SW +: SW] = release_of(thr_q, hyst_q);
  end
endmodule

// File: rtl/zs_hyst_flag.sv
module zs_hyst_flag #(
  parameter int NCH = 32,
  parameter int SW  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [NCH*SW-1:0] sum_flat,
  input  logic [NCH*SW-1:0] thr_flat,
  input  logic [NCH*SW-1:0] rel_flat,
  output logic [NCH-1:0]    set_ev,
  output logic [NCH-1:0]    clr_ev,
  output logic [NCH-1:0]    hit_q
);
  for (genvar i = 0; i < NCH; i++) begin : g_flag
    assign set_ev[i] = sample_valid && (sum_flat[i*SW +: SW] >= thr_flat[i*SW +: SW]);
    assign clr_ev[i] = sample_valid && (sum_flat[i*SW +: SW] <  rel_flat[i*SW +: SW]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hit_q[i] <= 1'b0;
      else if (set_ev[i]) hit_q[i] <= 1'b1;
      else if (clr_ev[i]) hit_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/zs_trig_edge.sv
module zs_trig_edge #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit_q,
  output logic           any_hit,
  output logic           trig
);
  logic any_d;
  assign any_hit = |hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) any_d <= 1'b0;
    else        any_d <= any_hit;
  end

  assign trig = any_hit && !any_d;
endmodule

// File: rtl/zs_neighbour_trigger.sv
module zs_neighbour_trigger
  import zs_pkg::*;
#(
  parameter int NCH = 32,
  parameter int AW  = 8,
  localparam int SW  = AW + 3,
  localparam int AAW = $clog2(NCH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [1:0]        win_sel,
  input  logic [NCH*AW-1:0] amp_bus,
  input  logic              thr_we,
  input  logic [AAW-1:0]    thr_addr,
  input  logic [SW-1:0]     thr_data,
  input  logic              hyst_we,
  input  logic [SW-1:0]     hyst_data,
  output logic [NCH-1:0]    hit_mask,
  output logic              trig_pulse
);
  win_e              win;
  logic [NCH*SW-1:0] sum_flat;
  logic [NCH*SW-1:0] thr_flat;
  logic [NCH*SW-1:0] rel_flat;
  logic [NCH-1:0]    set_ev;
  logic [NCH-1:0]    clr_ev;
  logic              any_hit;

  assign win = win_e'(win_sel);

  zs_win_sum #(.NCH(NCH), .AW(AW), .SW(SW)) u_sum (
    .amp_bus (amp_bus),
    .win     (win),
    .sum_flat(sum_flat)
  );

  zs_thr_bank #(.NCH(NCH), .SW(SW), .AAW(AAW)) u_thr (
    .clk      (clk),
    .rst_n    (rst_n),
    .thr_we   (thr_we),
    .thr_addr (thr_addr),
    .thr_data (thr_data),
    .hyst_we  (hyst_we),
    .hyst_data(hyst_data),
    .thr_flat (thr_flat),
    .rel_flat (rel_flat)
  );

  zs_hyst_flag #(.NCH(NCH), .SW(SW)) u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_valid(sample_valid),
    .sum_flat    (sum_flat),
    .thr_flat    (thr_flat),
    .rel_flat    (rel_flat),
    .set_ev      (set_ev),
    .clr_ev      (clr_ev),
    .hit_q       (hit_mask)
  );

  zs_trig_edge #(.NCH(NCH)) u_trig (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_q  (hit_mask),
    .any_hit(any_hit),
    .trig   (trig_pulse)
  );
endmodule

// File: rtl/zs_trigger_chk.sv
module zs_trigger_chk #(
  parameter int NCH = 32,
  parameter int AW  = 8,
  parameter int SW  = AW + 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_valid,
  input logic [NCH-1:0]    hit_mask,
  input logic              trig_pulse,
  input logic [NCH*SW-1:0] sum_flat,
  input logic [NCH*SW-1:0] thr_flat,
  input logic [NCH*SW-1:0] rel_flat
);
  localparam logic [SW-1:0] MAXSUM = SW'(5 * ((1 << AW) - 1));

  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse); // R8
  AST_TRIG_FROM_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> (hit_mask != '0) && ($past(hit_mask) == '0)); // R8
  AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(hit_mask)); // R7

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_SET_AT_THR: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid && (sum_flat[i*SW +: SW] >= thr_flat[i*SW +: SW]) |=> hit_mask[i]); // R5
    AST_CLEAR_BELOW_REL: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid && (sum_flat[i*SW +: SW] < rel_flat[i*SW +: SW]) |=> !hit_mask[i]); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      sum_flat[i*SW +: SW] <= MAXSUM); // R9
  end
endmodule

bind zs_neighbour_trigger zs_trigger_chk #(.NCH(NCH), .AW(AW), .SW(SW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_valid(sample_valid),
  .hit_mask    (hit_mask),
  .trig_pulse  (trig_pulse),
  .sum_flat    (sum_flat),
  .thr_flat    (thr_flat),
  .rel_flat    (rel_flat)
);

// File: tb/sim_zs_neighbour_trigger.sv
module sim_zs_neighbour_trigger;
  localparam int NCH = 32;
  localparam int AW  = 8;
  localparam int SW  = AW + 3;
  localparam int AAW = $clog2(NCH) + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sample_valid = 1'b0;
  logic [1:0]        win_sel = 2'd0;
  logic [NCH*AW-1:0] amp_bus = '0;
  logic              thr_we = 1'b0;
  logic [AAW-1:0]    thr_addr = '0;
  logic [SW-1:0]     thr_data = '0;
  logic              hyst_we = 1'b0;
  logic [SW-1:0]     hyst_data = '0;
  logic [NCH-1:0]    hit_mask;
  logic              trig_pulse;

  always #4 clk = ~clk; // 125 MHz

  zs_neighbour_trigger #(.NCH(NCH), .AW(AW)) u0 (.*);

  int checks = 0;
  int fails = 0;
  string tag = "R1";

  int amps[NCH];
  int thr_m[NCH];
  int hyst_m = 0;
  logic [NCH-1:0] exp_mask = '0;
  logic exp_trig = 1'b0;
  logic prev_any = 1'b0;

  function automatic int model_sum(int ch, int w);
    int lo = (w >= 2) ? 2 : 1;
    int hi = (w == 0) ? 1 : 2;
    int s = 0;
    for (int j = ch - lo; j <= ch + hi; j++)
      if (j >= 0 && j < NCH) s += amps[j];
    return s;
  endfunction

  task automatic drive_amps();
    for (int c = 0; c < NCH; c++) amp_bus[c*AW +: AW] = AW'(amps[c]);
  endtask

  task automatic clear_amps();
    for (int c = 0; c < NCH; c++) amps[c] = 0;
  endtask

  task automatic check(string what, logic [NCH-1:0] got, logic [NCH-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // one clock: update the model from the inputs present at the edge, then compare
  task automatic tick();
    int rel;
    int s;
    @(posedge clk);
    if (rst_n) begin
      if (sample_valid) begin
        for (int c = 0; c < NCH; c++) begin
          s = model_sum(c, int'(win_sel));
          rel = thr_m[c] - hyst_m;
          if (rel < 0) rel = 0;
          if (s >= thr_m[c]) exp_mask[c] = 1'b1;
          else if (s < rel)  exp_mask[c] = 1'b0;
        end
      end
      if (thr_we && int'(thr_addr) < NCH) thr_m[int'(thr_addr)] = int'(thr_data);
      if (hyst_we) hyst_m = int'(hyst_data);
      exp_trig = (exp_mask != '0) && !prev_any;
      prev_any = (exp_mask != '0);
    end
    #2;
    check("hit_mask", hit_mask, exp_mask);
    check("trig_pulse", {{(NCH-1){1'b0}}, trig_pulse}, {{(NCH-1){1'b0}}, exp_trig});
  endtask

  task automatic sample(int w);
    win_sel = 2'(w);
    drive_amps();
    sample_valid = 1'b1;
    tick();
    sample_valid = 1'b0;
    tick();
  endtask

  task automatic write_thr(int a, int v);
    thr_we = 1'b1; thr_addr = AAW'(a); thr_data = SW'(v);
    tick();
    thr_we = 1'b0;
  endtask

  task automatic write_hyst(int v);
    hyst_we = 1'b1; hyst_data = SW'(v);
    tick();
    hyst_we = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: got running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin amps[c] = 0; thr_m[c] = (1 << SW) - 1; end
    #1;
    tag = "R1";
    tick(); tick();
    #3 rst_n = 1'b1;
    tick();
    // R1: full-scale input must not hit with reset thresholds
    for (int c = 0; c < NCH; c++) amps[c] = 255;
    sample(2);
    clear_amps();

    // R4: out-of-range address must not alias onto channel 8
    tag = "R4";
    write_thr(NCH + 8, 0);
    sample(0);
    for (int c = 0; c < NCH; c++) write_thr(c, 100 + c);
    write_hyst(20);

    // R2 R5 R8: isolated pulse on channel 10
    tag = "R5";
    amps[10] = 120;
    sample(0);
    // R6: hold region then release
    tag = "R6";
    amps[10] = 100; sample(0);
    amps[10] = 80;  sample(0);
    amps[10] = 0;   sample(0);

    // R7: large amplitudes without a valid sample
    tag = "R7";
    for (int c = 0; c < NCH; c++) amps[c] = 200;
    drive_amps();
    tick(); tick();
    clear_amps(); drive_amps();

    // R2: edges
    tag = "R2";
    amps[0] = 60; amps[1] = 60; amps[NCH-1] = 130;
    sample(0);
    clear_amps(); sample(0);

    // R3: four- and five-channel windows
    tag = "R3";
    amps[12] = 110;
    sample(1);
    clear_amps(); sample(1);
    amps[20] = 125; amps[NCH-1] = 70; amps[NCH-3] = 70;
    sample(2);
    sample(3);
    clear_amps(); sample(2);

    // R6: hysteresis larger than threshold saturates release at zero
    tag = "R6";
    write_thr(5, 10);
    write_hyst(50);
    amps[5] = 12; sample(0);
    clear_amps(); sample(0);
    write_hyst(20);
    write_thr(5, 105);
    sample(0);

    // R9: full-scale five-channel sum
    tag = "R9";
    write_thr(15, 1275);
    for (int c = 0; c < NCH; c++) amps[c] = 255;
    sample(2);
    clear_amps(); sample(0);

    // R8 mixed: pseudo-random stream
    tag = "R8";
    for (int n = 0; n < 600; n++) begin
      for (int c = 0; c < NCH; c++) amps[c] = int'($urandom_range(0, 75));
      if ($urandom_range(0, 9) == 0) for (int c = 0; c < NCH; c++) amps[c] = 0;
      win_sel = 2'($urandom_range(0, 3));
      drive_amps();
      sample_valid = ($urandom_range(0, 3) != 0);
      if (n == 300) begin thr_we = 1'b1; thr_addr = AAW'(NCH + 3); thr_data = '0; end
      tick();
      thr_we = 1'b0;
    end
    sample_valid = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule